// File: doc/BRIEF.md
# Second-Order Digital Carrier-Tracking Loop

This block locks a local sinusoid to a sampled carrier that arrives as signed 16-bit converter samples. Each accepted sample is multiplied by the loop's own sine value. A one-pole low-pass stage smooths the product so that the slow phase-difference term is kept and the double-frequency term is attenuated. A proportional-plus-integral filter turns that error into a frequency correction. An oscillator built from a phase accumulator and a quarter-wave sine table closes the loop.

The filter is an ideal second-order type, taken from an analog prototype with about 0.707 damping through the bilinear mapping. Both of its coefficients are realised as sums of power-of-two shifts, so the filter contains no multipliers. All loop state advances by one step for each valid sample, so the correction computed from a sample already sets the phase step taken for that same sample. The loop outputs its sine sample, the registered control word and a lock flag.

Top module: `carrier_pll`

## Requirements
- R1: A synchronous active-high `rst` clears the phase accumulator, the integrator, the low-pass state, the lock run count, `ctrl_word` and `locked`. With the phase at zero, `nco_sine` shows the entry for table address 0.
- R2: `nco_sine` equals round(32767·sin(2π·(a+0.5)/1024)) to within 1 LSB, where a is bits [31:22] of the phase accumulator. The table stores one quarter wave; address bit 8 mirrors the index and address bit 9 negates the value.
- R3: On each valid sample the 32-bit phase accumulator advances by CENTRE_WORD plus the new control word shifted left by GAIN_SHL (4). The sum wraps modulo 2^32.
- R4: The detector value is (sample_in·nco_sine)>>>15, using the sine shown before the clock edge. The filtered error is e = lp + ((pd − lp)>>>LP_SHIFT) with LP_SHIFT = 3, and e becomes the new lp. All shifts are arithmetic (floor).
- R5: The proportional term is (e>>>4)+(e>>>5)+(e>>>8)+(e>>>9)+(e>>>10), which approximates a gain of 0.1006 using shifts and adds only.
- R6: The integrator adds (e>>>6)+(e>>>8) on each valid sample. It saturates at the signed INT_W (24-bit) limits [−2^23, 2^23−1] and never wraps.
- R7: `ctrl_word` is registered on each valid sample. Its value is the proportional term plus the updated integrator, saturated to 32 bits signed.
- R8: `locked` rises on the 256th consecutive valid sample with |e| < 256. It clears on the first valid sample with |e| ≥ 256.
- R9: While `sample_valid` is low, the phase, `nco_sine`, `ctrl_word` and `locked` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | The sample on `sample_in` is accepted on this edge |
| sample_in | input | 16 | Signed input sample |
| nco_sine | output | 16 | Signed local sine for the current phase |
| ctrl_word | output | 32 | Signed frequency correction of the last sample |
| locked | output | 1 | Lock indicator |

## Verification
The loop is driven with four input patterns, each of which exposes a different class of fault:
- A zero input keeps the error at exactly zero. This isolates the free-running phase step and the 256-sample lock count.
- A full-scale input whose sign follows the sine drives the error positive for tens of thousands of samples. This pushes the integrator into saturation and separates clamping from wrap-around.
- Uniform random samples with random valid gaps exercise the floor behaviour of every shift for negative values. They also test that idle cycles hold state.
- A clean sinusoid at a nearby frequency shows whether the one-sample feedback and the proportional and integral paths follow the cycle-exact reference.

// File: rtl/pll_math_pkg.sv
package pll_math_pkg;
  localparam int SAMPLE_W = 16;
  localparam int ERR_W    = 18;
  localparam int KP_TERMS = 5;
  localparam int KP_SH [KP_TERMS] = '{4, 5, 8, 9, 10};
  localparam int KI_SH0 = 6;
  localparam int KI_SH1 = 8;

  // Elaboration-time quarter-wave value, Taylor series to the 13th power.
  function automatic logic signed [SAMPLE_W-1:0] quarter_sine(int idx, int n_entries, int amp);
    real x, x2, term, acc;
    x    = (real'(idx) + 0.5) * 3.14159265358979 / (2.0 * real'(n_entries));
    x2   = x * x;
    term = x;
    acc  = x;
    for (int k = 1; k < 7; k++) begin
      term = -term * x2 / real'((2 * k) * (2 * k + 1));
      acc  = acc + term;
    end
    return SAMPLE_W'($rtoi(acc * real'(amp) + 0.5));
  endfunction

  function automatic logic signed [ERR_W-1:0] kp_shift_add(logic signed [ERR_W-1:0] e);
    logic signed [ERR_W-1:0] s;
    s = '0;
    for (int k = 0; k < KP_TERMS; k++) s = s + (e >>> KP_SH[k]);
    return s;
  endfunction

  function automatic logic signed [ERR_W-1:0] ki_shift_add(logic signed [ERR_W-1:0] e);
    return (e >>> KI_SH0) + (e >>> KI_SH1);
  endfunction
endpackage

// File: rtl/pll_detector.sv
module pll_detector
  import pll_math_pkg::*;
#(
  parameter int LP_SHIFT = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       valid,
  input  logic signed [SAMPLE_W-1:0] sample,
  input  logic signed [SAMPLE_W-1:0] lo_sine,
  output logic signed [ERR_W-1:0]    err_now
);
  localparam int PROD_W = 2 * SAMPLE_W;

  logic signed [PROD_W-1:0] prod;
  logic signed [ERR_W-1:0]  pd;
  logic signed [ERR_W:0]    diff;
  logic signed [ERR_W-1:0]  lp_q;

  assign prod    = sample * lo_sine;
  assign pd      = ERR_W'(prod >>> (SAMPLE_W - 1));
  assign diff    = (ERR_W+1)'(pd) - (ERR_W+1)'(lp_q);
  assign err_now = lp_q + ERR_W'(diff >>> LP_SHIFT);

  always_ff @(posedge clk) begin
    if (rst)        lp_q <= '0;
    else if (valid) lp_q <= err_now;
  end
endmodule

// File: rtl/pll_loop_filter.sv
module pll_loop_filter
  import pll_math_pkg::*;
#(
  parameter int INT_W  = 24,
  parameter int CTRL_W = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     valid,
  input  logic signed [ERR_W-1:0]  err_now,
  output logic signed [CTRL_W-1:0] ctrl_next,
  output logic signed [CTRL_W-1:0] ctrl_q,
  output logic signed [INT_W-1:0]  integ_q,
  output logic signed [ERR_W-1:0]  ki_step
);
  localparam logic signed [INT_W:0]  IMAX = {2'b00, {(INT_W-1){1'b1}}};
  localparam logic signed [INT_W:0]  IMIN = {2'b11, {(INT_W-1){1'b0}}};
  localparam logic signed [CTRL_W:0] CMAX = {2'b00, {(CTRL_W-1){1'b1}}};
  localparam logic signed [CTRL_W:0] CMIN = {2'b11, {(CTRL_W-1){1'b0}}};

  logic signed [ERR_W-1:0]  kp_val;
  logic signed [INT_W:0]    isum;
  logic signed [INT_W-1:0]  integ_next;
  logic signed [CTRL_W:0]   csum;

  assign kp_val  = kp_shift_add(err_now);
  assign ki_step = ki_shift_add(err_now);
  assign isum    = (INT_W+1)'(integ_q) + (INT_W+1)'(ki_step);

  always_comb begin
    if (isum > IMAX)      integ_next = IMAX[INT_W-1:0];
    else if (isum < IMIN) integ_next = IMIN[INT_W-1:0];
    else                  integ_next = isum[INT_W-1:0];
  end

  assign csum = (CTRL_W+1)'(kp_val) + (CTRL_W+1)'(integ_next);

  always_comb begin
    if (csum > CMAX)      ctrl_next = CMAX[CTRL_W-1:0];
    else if (csum < CMIN) ctrl_next = CMIN[CTRL_W-1:0];
    else                  ctrl_next = csum[CTRL_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      integ_q <= '0;
      ctrl_q  <= '0;
    end else if (valid) begin
      integ_q <= integ_next;
      ctrl_q  <= ctrl_next;
    end
  end
endmodule

// File: rtl/pll_nco.sv
module pll_nco
  import pll_math_pkg::*;
#(
  parameter int              PHASE_W     = 32,
  parameter int              CTRL_W      = 32,
  parameter int              LUT_ADDR_W  = 10,
  parameter int              GAIN_SHL    = 4,
  parameter logic [31:0]     CENTRE_WORD = 32'h0A3D_70A4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       valid,
  input  logic signed [CTRL_W-1:0]   ctrl_next,
  output logic [PHASE_W-1:0]         phase_q,
  output logic signed [SAMPLE_W-1:0] sine
);
  localparam int IDX_W = LUT_ADDR_W - 2;
  localparam int QN    = 1 << IDX_W;
  localparam int AMP   = (1 << (SAMPLE_W - 1)) - 1;

  logic signed [SAMPLE_W-1:0] rom [QN];
  logic [LUT_ADDR_W-1:0]      addr;
  logic [IDX_W-1:0]           idx;
  logic signed [SAMPLE_W-1:0] mag;
  logic [PHASE_W-1:0]         step;

  for (genvar gi = 0; gi < QN; gi++) begin : g_rom
    assign rom[gi] = quarter_sine(gi, QN, AMP);
  end

  assign addr = phase_q[PHASE_W-1 -: LUT_ADDR_W];
  assign idx  = addr[LUT_ADDR_W-2] ? ~addr[IDX_W-1:0] : addr[IDX_W-1:0];
  assign mag  = rom[idx];
  assign sine = addr[LUT_ADDR_W-1] ? -mag : mag;
  assign step = PHASE_W'(CENTRE_WORD) + (PHASE_W'(ctrl_next) << GAIN_SHL);

  always_ff @(posedge clk) begin
    if (rst)        phase_q <= '0;
    else if (valid) phase_q <= phase_q + step;
  end
endmodule

// File: rtl/pll_lock_watch.sv
module pll_lock_watch
  import pll_math_pkg::*;
#(
  parameter int LOCK_THRESH = 256,
  parameter int LOCK_LEN    = 256
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    valid,
  input  logic signed [ERR_W-1:0] err_now,
  output logic                    in_win,
  output logic                    locked
);
  localparam int CNT_W = $clog2(LOCK_LEN + 1);

  logic [ERR_W-1:0] mag;
  logic [CNT_W-1:0] run_q;

  assign mag    = err_now[ERR_W-1] ? ERR_W'(-err_now) : ERR_W'(err_now);
  assign in_win = mag < ERR_W'(LOCK_THRESH);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= '0;
      locked <= 1'b0;
    end else if (valid) begin
      if (!in_win) begin
        run_q  <= '0;
        locked <= 1'b0;
      end else begin
        if (run_q != CNT_W'(LOCK_LEN)) run_q <= run_q + 1'b1;
        if (run_q == CNT_W'(LOCK_LEN - 1)) locked <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/carrier_pll.sv
module carrier_pll
  import pll_math_pkg::*;
#(
  parameter int          PHASE_W     = 32,
  parameter int          CTRL_W      = 32,
  parameter int          INT_W       = 24,
  parameter int          LUT_ADDR_W  = 10,
  parameter int          LP_SHIFT    = 3,
  parameter int          GAIN_SHL    = 4,
  parameter int          LOCK_THRESH = 256,
  parameter int          LOCK_LEN    = 256,
  parameter logic [31:0] CENTRE_WORD = 32'h0A3D_70A4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sample_valid,
  input  logic signed [SAMPLE_W-1:0] sample_in,
  output logic signed [SAMPLE_W-1:0] nco_sine,
  output logic signed [CTRL_W-1:0]   ctrl_word,
  output logic                       locked
);
  logic signed [ERR_W-1:0]  err_now;
  logic signed [CTRL_W-1:0] ctrl_next;
  logic signed [INT_W-1:0]  integ_q;
  logic signed [ERR_W-1:0]  ki_step;
  logic [PHASE_W-1:0]       phase_q;
  logic                     in_win;

  pll_detector #(.LP_SHIFT(LP_SHIFT)) u_det (
    .clk(clk), .rst(rst), .valid(sample_valid),
    .sample(sample_in), .lo_sine(nco_sine), .err_now(err_now)
  );

  pll_loop_filter #(.INT_W(INT_W), .CTRL_W(CTRL_W)) u_filt (
    .clk(clk), .rst(rst), .valid(sample_valid), .err_now(err_now),
    .ctrl_next(ctrl_next), .ctrl_q(ctrl_word), .integ_q(integ_q), .ki_step(ki_step)
  );

  pll_nco #(
    .PHASE_W(PHASE_W), .CTRL_W(CTRL_W), .LUT_ADDR_W(LUT_ADDR_W),
    .GAIN_SHL(GAIN_SHL), .CENTRE_WORD(CENTRE_WORD)
  ) u_nco (
    .clk(clk), .rst(rst), .valid(sample_valid), .ctrl_next(ctrl_next),
    .phase_q(phase_q), .sine(nco_sine)
  );

  pll_lock_watch #(.LOCK_THRESH(LOCK_THRESH), .LOCK_LEN(LOCK_LEN)) u_lock (
    .clk(clk), .rst(rst), .valid(sample_valid), .err_now(err_now),
    .in_win(in_win), .locked(locked)
  );
endmodule

// File: rtl/carrier_pll_checker.sv
module carrier_pll_checker
  import pll_math_pkg::*;
#(
  parameter int PHASE_W = 32,
  parameter int CTRL_W  = 32,
  parameter int INT_W   = 24
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       sample_valid,
  input logic                       locked,
  input logic                       in_win,
  input logic signed [CTRL_W-1:0]   ctrl_word,
  input logic signed [SAMPLE_W-1:0] nco_sine,
  input logic [PHASE_W-1:0]         phase_q,
  input logic signed [INT_W-1:0]    integ_q,
  input logic signed [ERR_W-1:0]    ki_step
);
  // R1: reset clears phase, control word and lock
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (phase_q == '0 && ctrl_word == '0 && !locked && integ_q == '0));

  // R9: idle cycles hold all loop outputs
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !sample_valid |=> ($stable(phase_q) && $stable(ctrl_word) && $stable(locked) && $stable(nco_sine)));

  // R8: an out-of-window sample drops lock
  p_lock_drop_r8: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && !in_win) |=> !locked);

  // R8: lock only rises after an in-window valid sample
  p_lock_rise_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(sample_valid && in_win));

  // R6: a non-negative step never lowers the integrator (no wrap)
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && ki_step >= 0) |=> (integ_q >= $past(integ_q)));

  // R6: a non-positive step never raises the integrator (no wrap)
  p_no_underflow_r6: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && ki_step <= 0) |=> (integ_q <= $past(integ_q)));
endmodule

bind carrier_pll carrier_pll_checker #(
  .PHASE_W(PHASE_W), .CTRL_W(CTRL_W), .INT_W(INT_W)
) u_checker (
  .clk(clk), .rst(rst), .sample_valid(sample_valid), .locked(locked),
  .in_win(in_win), .ctrl_word(ctrl_word), .nco_sine(nco_sine),
  .phase_q(phase_q), .integ_q(integ_q), .ki_step(ki_step)
);

// File: tb/test_carrier_pll.sv
module test_carrier_pll;
  localparam int CLK_PERIOD = 10;
  localparam bit [31:0] CENTRE = 32'h0A3D_70A4;
  localparam int IMAX = (1 << 23) - 1;
  localparam int IMIN = -(1 << 23);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sample_valid = 1'b0;
  logic signed [15:0] sample_in = '0;
  logic signed [15:0] nco_sine;
  logic signed [31:0] ctrl_word;
  logic locked;

  int checks = 0;
  int errors = 0;

  // bench reference state
  int        m_lp, m_integ, m_ctrl, m_run;
  bit        m_lock;
  bit [31:0] m_phase;

  carrier_pll i_carrier_pll (
    .clk(clk), .rst(rst), .sample_valid(sample_valid), .sample_in(sample_in),
    .nco_sine(nco_sine), .ctrl_word(ctrl_word), .locked(locked)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int exp_sine(bit [31:0] ph);
    real a, v;
    a = 2.0 * 3.14159265358979 * (real'(ph[31:22]) + 0.5) / 1024.0;
    v = 32767.0 * $sin(a);
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  function automatic int clampi(longint v, int lo, int hi);
    if (v > hi) return hi;
    if (v < lo) return lo;
    return int'(v);
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_outputs();
    int es;
    es = exp_sine(m_phase);
    check(ctrl_word == m_ctrl, "R4 R5 R6 R7 ctrl_word", ctrl_word, m_ctrl);
    check(locked == m_lock, "R8 locked", locked, m_lock);
    check((int'(nco_sine) - es <= 1) && (es - int'(nco_sine) <= 1), "R2 R3 nco_sine", nco_sine, es);
  endtask

  task automatic do_reset();
    rst = 1'b1; sample_valid = 1'b0; sample_in = '0;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    rst = 1'b0;
    m_lp = 0; m_integ = 0; m_ctrl = 0; m_run = 0; m_lock = 0; m_phase = '0;
  endtask

  // Drive one cycle; reference updates with the sine shown before the edge.
  task automatic step(int x, bit v);
    int s, pd, e, kp, ki;
    s = int'(nco_sine);
    if (v) begin
      pd = (x * s) >>> 15;
      e  = m_lp + ((pd - m_lp) >>> 3);
      m_lp = e;
      kp = (e >>> 4) + (e >>> 5) + (e >>> 8) + (e >>> 9) + (e >>> 10);
      ki = (e >>> 6) + (e >>> 8);
      m_integ = clampi(longint'(m_integ) + ki, IMIN, IMAX);
      m_ctrl  = clampi(longint'(kp) + m_integ, 32'sh8000_0000, 32'sh7FFF_FFFF);
      m_phase = m_phase + CENTRE + (32'(m_ctrl) << 4);
      if (e < 256 && e > -256) begin
        if (m_run < 256) m_run++;
        if (m_run == 256) m_lock = 1;
      end else begin
        m_run = 0; m_lock = 0;
      end
    end
    sample_in = 16'(x);
    sample_valid = v;
    @(posedge clk);
    #(CLK_PERIOD/4);
    check_outputs();
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    int hold_c, hold_s, n;
    void'($urandom(32'd20240611));
    do_reset();
    // R1: reset state
    check(ctrl_word == 0, "R1 ctrl_word after reset", ctrl_word, 0);
    check(locked == 1'b0, "R1 locked after reset", locked, 0);
    check(int'(nco_sine) == exp_sine(32'd0) || int'(nco_sine) == exp_sine(32'd0) - 1,
          "R1 nco_sine at phase 0", nco_sine, exp_sine(32'd0));

    // R8: zero input, lock after exactly 256 samples
    for (int i = 0; i < 255; i++) step(0, 1'b1);
    check(locked == 1'b0, "R8 not locked after 255", locked, 0);
    step(0, 1'b1);
    check(locked == 1'b1, "R8 locked after 256", locked, 1);
    // R3: zero input leaves only the centre step
    check(ctrl_word == 0, "R3 zero error gives zero correction", ctrl_word, 0);

    // R8: large correlated input drops lock
    n = 0;
    while (m_lock && n < 40) begin
      step((nco_sine >= 0) ? 32767 : -32767, 1'b1);
      n++;
    end
    check(locked == 1'b0, "R8 lock cleared by large error", locked, 0);

    // R9: idle cycles change nothing
    hold_c = ctrl_word; hold_s = nco_sine;
    for (int i = 0; i < 20; i++) step(int'($urandom_range(65535)) - 32768, 1'b0);
    check(ctrl_word == hold_c, "R9 ctrl_word held while idle", ctrl_word, hold_c);
    check(int'(nco_sine) == hold_s, "R9 nco_sine held while idle", nco_sine, hold_s);

    // R4 R5 R6 R7: random samples with random valid gaps
    do_reset();
    for (int i = 0; i < 3000; i++)
      step(int'($urandom_range(65535)) - 32768, ($urandom_range(9) < 8));

    // R3 R7: clean nearby-frequency tone
    do_reset();
    for (int i = 0; i < 4000; i++)
      step($rtoi(20000.0 * $sin(2.0 * 3.14159265358979 * 0.041 * real'(i))), 1'b1);

    // R6: saturate integrator with sign-following full-scale input
    do_reset();
    for (int i = 0; i < 30000; i++) step((nco_sine >= 0) ? 32767 : -32767, 1'b1);
    check(m_integ == IMAX, "R6 reference reached integrator limit", m_integ, IMAX);
    check(ctrl_word > IMAX - 4096 && ctrl_word <= IMAX + 4096,
          "R6 ctrl_word at saturated integrator", ctrl_word, m_ctrl);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule